// File: doc/BRIEF.md
# Banked RAM Expansion Controller with Base-RAM Shadow

This controller sits on the bus of an 8-bit home computer that has 64KB of base RAM, and it adds up to 4MB of external RAM. The external RAM is organised as 64 pages of 64KB, and each page holds four 16KB banks. The controller watches the address, data and strobe lines of the CPU. It catches writes to a banking port and stores a page number and one of eight mapping modes. For every memory cycle that follows, it works out whether each 16KB CPU window goes to base RAM or to an external bank. It then drives a 22-bit external address, a chip select, a base-RAM disable line, an A15 override and the strobe overrides.

Some machines cannot remap their base RAM natively. For these, a shadow option keeps a copy of base RAM in the top external page (page 63). Every CPU write to base RAM is also written to that page. CPU reads of base RAM are served from the copy, with base RAM disabled. Video fetches still read the real base RAM. With this arrangement, the mode that moves the screen window works on those machines.

The option switches are latched only while reset is held. The current page, the mode and the latched switches can be read back on an IO port.

All outputs are registered: they show the result for the bus cycle sampled at the previous clock edge.

Top module: `ram_expander_ctrl`

## Requirements
- R1: An IO write (IORQ and WR low) with A15=0 and data bits 7:6 = 11 loads the mode from data bits 2:0 and the low three page bits from data bits 5:3. The same write loads the high three page bits from the inverted address bits 5:3.
- R2: An IO write whose A15 is 1, or whose data bits 7:6 are not 11, leaves the page and the mode unchanged.
- R3: While reset is asserted, the page and the mode clear to 0, all bus outputs are deasserted, and the switch inputs are latched.
- R4: With the shadow option off, a memory cycle that maps to base RAM in an unmoved window gives xram_cs=0, base_ram_dis=0 and no A15 override.
- R5: Each window is mapped by mode as follows. Mode 0 maps every window to base RAM. Mode 1 maps window 3 to bank 3. Mode 2 maps window w to bank w. Mode 3 maps window 3 to bank 3 and window 1 to base window 3. Modes 4 to 7 map window 1 to bank (mode-4). Any window not listed maps to base RAM in the same window.
- R6: An access mapped to an external bank asserts xram_cs and base_ram_dis, with xram_addr = {page, bank, A13:A0}.
- R7: A base-RAM access that the controller moves to another window (mode 3, window 1) and that is not disabled asserts a15_oe, with a15_out equal to bit 1 of the target window.
- R8: With the shadow option on (switch bit 0 = 1), a CPU write to base RAM asserts xram_cs with base_ram_dis=0, at address {page 63, target window, A13:A0}.
- R9: With the shadow option on, a CPU read of base RAM asserts xram_cs and base_ram_dis at the page-63 address, and no A15 override is driven.
- R10: A memory read flagged as a video fetch always uses base RAM: xram_cs=0, base_ram_dis=0, no overrides.
- R11: rd_ovr_en is asserted for each CPU read served by external RAM. wr_ovr_en is asserted for each write served only by an external bank.
- R12: An IO read with A15:A8 = 0xFD asserts io_rd_oe one cycle later. The returned data is selected by A1:A0: 0 gives the page, 1 gives the mode, 2 gives the latched switches.
- R13: Changes on the switch inputs after reset has been released do not change the latched value seen through the readback port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU data bus (write data) |
| iorq_n | input | 1 | IO request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| vid_fetch | input | 1 | Current memory read is a video fetch |
| dip_sw | input | 8 | Option switches, bit 0 enables shadow |
| xram_addr | output | 22 | External RAM address |
| xram_cs | output | 1 | External RAM select, active high |
| base_ram_dis | output | 1 | Disable base RAM for this cycle |
| a15_oe | output | 1 | Enable A15 override |
| a15_out | output | 1 | Value driven on A15 when overriding |
| rd_ovr_en | output | 1 | Read strobe override enable |
| wr_ovr_en | output | 1 | Write strobe override enable |
| io_rd_data | output | 8 | Readback port data |
| io_rd_oe | output | 1 | Readback data valid |

## Verification
The hardest case to reach is the combination of shadow mode with mode 3, window 1. There a base-RAM write must be moved to window 3 with the A15 override and also copied to page 63 bank 3. A read of the same window must come from page 63 with no override. Random stimulus reaches this case only when a configuration write has selected mode 3 and the shadow switch was latched at reset. The bench therefore runs a random phase after a reset with the shadow switch on, and it adds directed accesses to window 1 with both polarities of the shadow switch.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef struct packed {
    logic       ext;       // window goes to an external bank
    logic [1:0] bank;      // external bank number
    logic [1:0] base_win;  // base window when not external
  } xr_map_t;
endpackage

// File: rtl/xr_cfg_regs.sv
module xr_cfg_regs #(
  parameter int PAGE_BITS = 6,
  parameter int SW_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 a15,
  input  logic [2:0]           a_hi_sel,
  input  logic [7:0]           din,
  input  logic                 iorq_n,
  input  logic                 wr_n,
  input  logic [SW_W-1:0]      dip_sw,
  output logic [PAGE_BITS-1:0] page,
  output logic [2:0]           mode,
  output logic [SW_W-1:0]      sw_q
);
  localparam int LO_BITS = 3;
  localparam int HI_BITS = PAGE_BITS - LO_BITS;

  logic                 cfg_hit;
  logic [PAGE_BITS-1:0] page_nxt;

  assign cfg_hit = !iorq_n && !wr_n && !a15 && (din[7:6] == 2'b11);

  generate
    if (HI_BITS > 0) begin : g_hi
      assign page_nxt = {~a_hi_sel[HI_BITS-1:0], din[5:3]};
    end else begin : g_lo
      assign page_nxt = din[5:3];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      mode <= '0;
      sw_q <= dip_sw;
    end else if (cfg_hit) begin
      page <= page_nxt;
      mode <= din[2:0];
    end
  end
endmodule

// File: rtl/xr_map_decode.sv
module xr_map_decode
  import xr_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] win,
  output xr_map_t    map
);
  always_comb begin
    map.ext      = 1'b0;
    map.bank     = win;
    map.base_win = win;
    unique case (mode)
      3'd0: ;
      3'd1: if (win == 2'd3) begin map.ext = 1'b1; map.bank = 2'd3; end
      3'd2: begin map.ext = 1'b1; map.bank = win; end
      3'd3: begin
        if (win == 2'd3) begin map.ext = 1'b1; map.bank = 2'd3; end
        else if (win == 2'd1) map.base_win = 2'd3;
      end
      default: if (win == 2'd1) begin map.ext = 1'b1; map.bank = mode[1:0]; end
    endcase
  end
endmodule

// File: rtl/xr_readback.sv
module xr_readback #(
  parameter int         PAGE_BITS = 6,
  parameter int         SW_W      = 8,
  parameter logic [7:0] PORT_HI   = 8'hFD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           a_hi,
  input  logic [1:0]           sel,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic [PAGE_BITS-1:0] page,
  input  logic [2:0]           mode,
  input  logic [SW_W-1:0]      sw_q,
  output logic [7:0]           rd_data,
  output logic                 rd_oe
);
  logic hit;
  assign hit = !iorq_n && !rd_n && (a_hi == PORT_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_oe <= hit;
      if (hit) begin
        unique case (sel)
          2'd0:    rd_data <= 8'(page);
          2'd1:    rd_data <= 8'(mode);
          2'd2:    rd_data <= 8'(sw_q);
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ram_expander_ctrl.sv
module ram_expander_ctrl
  import xr_pkg::*;
#(
  parameter int         PAGE_BITS = 6,
  parameter int         SW_W      = 8,
  parameter logic [7:0] PORT_HI   = 8'hFD,
  parameter int         OFF_W     = 14,
  parameter int         XADDR_W   = PAGE_BITS + 2 + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_din,
  input  logic               iorq_n,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               vid_fetch,
  input  logic [SW_W-1:0]    dip_sw,
  output logic [XADDR_W-1:0] xram_addr,
  output logic               xram_cs,
  output logic               base_ram_dis,
  output logic               a15_oe,
  output logic               a15_out,
  output logic               rd_ovr_en,
  output logic               wr_ovr_en,
  output logic [7:0]         io_rd_data,
  output logic               io_rd_oe
);
  localparam logic [PAGE_BITS-1:0] SHADOW_PAGE = '1;

  logic [PAGE_BITS-1:0] cur_page;
  logic [2:0]           cur_mode;
  logic [SW_W-1:0]      sw_q;
  xr_map_t              map;
  logic                 mem_rd, mem_wr, shadow_on, moved;
  logic [1:0]           win;
  logic [OFF_W-1:0]     off;

  assign win       = cpu_addr[15:14];
  assign off       = cpu_addr[OFF_W-1:0];
  assign mem_rd    = !mreq_n && !rd_n;
  assign mem_wr    = !mreq_n && !wr_n;
  assign shadow_on = sw_q[0];
  assign moved     = map.base_win[1] != win[1];

  xr_cfg_regs #(.PAGE_BITS(PAGE_BITS), .SW_W(SW_W)) u_cfg (
    .clk(clk), .rst(rst), .a15(cpu_addr[15]), .a_hi_sel(cpu_addr[5:3]),
    .din(cpu_din), .iorq_n(iorq_n), .wr_n(wr_n), .dip_sw(dip_sw),
    .page(cur_page), .mode(cur_mode), .sw_q(sw_q)
  );

  xr_map_decode u_map (.mode(cur_mode), .win(win), .map(map));

  xr_readback #(.PAGE_BITS(PAGE_BITS), .SW_W(SW_W), .PORT_HI(PORT_HI)) u_rb (
    .clk(clk), .rst(rst), .a_hi(cpu_addr[15:8]), .sel(cpu_addr[1:0]),
    .iorq_n(iorq_n), .rd_n(rd_n), .page(cur_page), .mode(cur_mode),
    .sw_q(sw_q), .rd_data(io_rd_data), .rd_oe(io_rd_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xram_addr    <= '0;
      xram_cs      <= 1'b0;
      base_ram_dis <= 1'b0;
      a15_oe       <= 1'b0;
      a15_out      <= 1'b0;
      rd_ovr_en    <= 1'b0;
      wr_ovr_en    <= 1'b0;
    end else begin
      xram_cs      <= 1'b0;
      base_ram_dis <= 1'b0;
      a15_oe       <= 1'b0;
      a15_out      <= 1'b0;
      rd_ovr_en    <= 1'b0;
      wr_ovr_en    <= 1'b0;
      if ((mem_rd || mem_wr) && !vid_fetch) begin
        if (map.ext) begin
          xram_cs      <= 1'b1;
          xram_addr    <= {cur_page, map.bank, off};
          base_ram_dis <= 1'b1;
          rd_ovr_en    <= mem_rd;
          wr_ovr_en    <= mem_wr;
        end else if (shadow_on && mem_rd) begin
          xram_cs      <= 1'b1;
          xram_addr    <= {SHADOW_PAGE, map.base_win, off};
          base_ram_dis <= 1'b1;
          rd_ovr_en    <= 1'b1;
        end else begin
          if (shadow_on) begin
            xram_cs   <= 1'b1;
            xram_addr <= {SHADOW_PAGE, map.base_win, off};
          end
          a15_oe  <= moved;
          a15_out <= map.base_win[1];
        end
      end
    end
  end
endmodule

// File: rtl/xr_chk.sv
module xr_chk (
  input logic       clk,
  input logic       rst,
  input logic       iorq_n,
  input logic       mreq_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       vid_fetch,
  input logic [2:0] cur_mode,
  input logic [5:0] cur_page,
  input logic       xram_cs,
  input logic       base_ram_dis,
  input logic       a15_oe,
  input logic       rd_ovr_en,
  input logic       io_rd_oe
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(!iorq_n && !wr_n) |-> ($stable(cur_mode) && $stable(cur_page))); // R2
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (rst)
    $past(mreq_n) |-> (!xram_cs && !base_ram_dis && !a15_oe)); // R4
  AST_DIS_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    base_ram_dis |-> xram_cs); // R6
  AST_A15_NOT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    a15_oe |-> !base_ram_dis); // R7
  AST_VIDEO_BASE: assert property (@(posedge clk) disable iff (rst)
    $past(vid_fetch && !mreq_n) |-> (!xram_cs && !base_ram_dis && !a15_oe)); // R10
  AST_RD_OVR_READ: assert property (@(posedge clk) disable iff (rst)
    rd_ovr_en |-> $past(!rd_n && !mreq_n)); // R11
  AST_RB_STROBE: assert property (@(posedge clk) disable iff (rst)
    io_rd_oe |-> $past(!iorq_n && !rd_n)); // R12
endmodule

bind ram_expander_ctrl xr_chk u_chk (
  .clk(clk), .rst(rst), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n),
  .wr_n(wr_n), .vid_fetch(vid_fetch), .cur_mode(cur_mode),
  .cur_page(cur_page), .xram_cs(xram_cs), .base_ram_dis(base_ram_dis),
  .a15_oe(a15_oe), .rd_ovr_en(rd_ovr_en), .io_rd_oe(io_rd_oe)
);

// File: tb/ram_expander_ctrl_tb_top.sv
`timescale 1ns/1ps
module ram_expander_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_din = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        vid_fetch = 1'b0;
  logic [7:0]  dip_sw = '0;
  logic [21:0] xram_addr;
  logic        xram_cs, base_ram_dis, a15_oe, a15_out, rd_ovr_en, wr_ovr_en;
  logic [7:0]  io_rd_data;
  logic        io_rd_oe;

  int errors = 0;
  int checks = 0;
  logic [5:0] m_page;
  logic [2:0] m_mode;
  logic       m_shadow;
  logic [7:0] m_sw;

  ram_expander_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .vid_fetch(vid_fetch), .dip_sw(dip_sw), .xram_addr(xram_addr),
    .xram_cs(xram_cs), .base_ram_dis(base_ram_dis), .a15_oe(a15_oe),
    .a15_out(a15_out), .rd_ovr_en(rd_ovr_en), .wr_ovr_en(wr_ovr_en),
    .io_rd_data(io_rd_data), .io_rd_oe(io_rd_oe)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; vid_fetch = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] sw);
    @(negedge clk);
    rst = 1'b1; dip_sw = sw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_page = '0; m_mode = '0; m_sw = sw; m_shadow = sw[0];
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_din = d; iorq_n = 1'b0; wr_n = 1'b0;
    if (!a[15] && d[7:6] == 2'b11) begin
      m_page = {~a[5:3], d[5:3]};
      m_mode = d[2:0];
    end
    @(posedge clk);
    go_idle();
  endtask

  task automatic io_rd(input logic [1:0] sel, input string req, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = {8'hFD, 6'b0, sel}; iorq_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); #1;
    chk({req, " readback valid"}, 32'(io_rd_oe), 32'd1);
    chk({req, " readback data"}, 32'(io_rd_data), 32'(exp));
    go_idle();
  endtask

  task automatic check_state(input string req);
    io_rd(2'd0, req, 8'(m_page));
    io_rd(2'd1, req, 8'(m_mode));
  endtask

  // expected window mapping from R5
  task automatic exp_map(input logic [2:0] md, input logic [1:0] w,
                         output logic ext, output logic [1:0] bank, output logic [1:0] bw);
    ext = 1'b0; bank = 2'd0; bw = w;
    if (md == 3'd1 && w == 2'd3) begin ext = 1'b1; bank = 2'd3; end
    if (md == 3'd2) begin ext = 1'b1; bank = w; end
    if (md == 3'd3) begin
      if (w == 2'd3) begin ext = 1'b1; bank = 2'd3; end
      if (w == 2'd1) bw = 2'd3;
    end
    if (md >= 3'd4 && w == 2'd1) begin ext = 1'b1; bank = md[1:0]; end
  endtask

  task automatic mem_op(input logic [15:0] a, input logic is_wr, input logic vid, input string req);
    logic ext, e_cs, e_dis, e_oe, e_rdo, e_wro;
    logic [1:0] bank, bw;
    logic [21:0] e_addr;
    exp_map(m_mode, a[15:14], ext, bank, bw);
    e_cs = 0; e_dis = 0; e_oe = 0; e_rdo = 0; e_wro = 0; e_addr = '0;
    if (!vid) begin
      if (ext) begin
        e_cs = 1; e_dis = 1; e_rdo = !is_wr; e_wro = is_wr;
        e_addr = {m_page, bank, a[13:0]};
      end else if (m_shadow) begin
        e_cs = 1; e_addr = {6'h3F, bw, a[13:0]};
        if (!is_wr) begin e_dis = 1; e_rdo = 1; end
        else e_oe = (bw != a[15:14]);
      end else begin
        e_oe = (bw != a[15:14]);
      end
    end
    @(negedge clk);
    cpu_addr = a; mreq_n = 1'b0; rd_n = is_wr; wr_n = !is_wr; vid_fetch = vid;
    cpu_din = 8'($urandom);
    @(posedge clk); #1;
    chk({req, " xram_cs"}, 32'(xram_cs), 32'(e_cs));
    chk({req, " base_ram_dis"}, 32'(base_ram_dis), 32'(e_dis));
    chk({req, " a15_oe"}, 32'(a15_oe), 32'(e_oe));
    if (e_oe) chk({req, " a15_out"}, 32'(a15_out), 32'(bw[1]));
    chk({req, " R11 rd_ovr_en"}, 32'(rd_ovr_en), 32'(e_rdo));
    chk({req, " R11 wr_ovr_en"}, 32'(wr_ovr_en), 32'(e_wro));
    if (e_cs) chk({req, " xram_addr"}, 32'(xram_addr), 32'(e_addr));
    go_idle();
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      logic [15:0] a;
      logic [7:0] d;
      k = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if (k < 2) begin
        a[15] = 1'b0; d = {2'b11, 6'($urandom)};
        io_wr(a, d);
      end else if (k == 2) begin
        d = 8'($urandom);
        if (d[7:6] == 2'b11) a[15] = 1'b1;
        io_wr(a, d);
        check_state("R2 random ignored write");
      end else begin
        logic w, v;
        w = 1'($urandom);
        v = !w && ($urandom_range(0, 5) == 0);
        mem_op(a, w, v, v ? "R10 random video" : "R5 R6 R8 R9 random access");
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    do_reset(8'h5A);
    @(posedge clk); #1;
    chk("R3 xram_cs after reset", 32'(xram_cs), 32'd0);
    chk("R3 base_ram_dis after reset", 32'(base_ram_dis), 32'd0);
    chk("R3 a15_oe after reset", 32'(a15_oe), 32'd0);
    check_state("R3 reset state");
    io_rd(2'd2, "R3 switch latch", 8'h5A);
    dip_sw = 8'hFF;
    io_rd(2'd2, "R13 switch change after reset", 8'h5A);

    mem_op(16'h4123, 1'b0, 1'b0, "R4 mode0 read");
    mem_op(16'hC000, 1'b1, 1'b0, "R4 mode0 write");

    io_wr(16'h0038, 8'b11_111_010);   // page 7, high bits ~111 = 0
    check_state("R1 config decode");
    io_wr(16'h0000, 8'b11_111_100);   // page 63, mode 4
    check_state("R1 page 63");
    mem_op(16'h7FFF, 1'b0, 1'b0, "R6 mode4 window1 read");
    io_wr(16'h8000, 8'b11_000_001);
    check_state("R2 A15 high ignored");
    io_wr(16'h0010, 8'b10_000_001);
    check_state("R2 bad top bits ignored");
    io_wr(16'h0028, 8'b11_010_011);   // mode 3
    mem_op(16'h4001, 1'b1, 1'b0, "R7 mode3 window1 write");
    mem_op(16'h5000, 1'b0, 1'b0, "R7 mode3 window1 read");
    mem_op(16'hC010, 1'b1, 1'b0, "R6 mode3 window3 write");
    mem_op(16'h4010, 1'b0, 1'b1, "R10 video fetch window1");
    io_wr(16'h0008, 8'b11_101_010);   // mode 2
    for (int w = 0; w < 4; w++)
      mem_op({2'(w), 14'h0ABC}, 1'b0, 1'b0, "R5 mode2 each window");
    rand_phase(400);

    do_reset(8'h81);
    check_state("R3 second reset");
    mem_op(16'h1234, 1'b1, 1'b0, "R8 shadow write mode0");
    mem_op(16'h1234, 1'b0, 1'b0, "R9 shadow read mode0");
    mem_op(16'h9234, 1'b0, 1'b1, "R10 shadow video read");
    io_wr(16'h0038, 8'b11_000_011);
    mem_op(16'h4444, 1'b1, 1'b0, "R8 R7 shadow mode3 window1 write");
    mem_op(16'h4444, 1'b0, 1'b0, "R9 shadow mode3 window1 read");
    rand_phase(400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule